// File: doc/BRIEF.md
# Digit Pointer and Word-Select Generator

This block keeps a four-bit digit pointer into a fourteen-digit register that is processed serially, four bit times per digit, for fifty-six bit times per instruction word. The pointer can be loaded from an immediate value, stepped up or down with wrap-around, or compared against an immediate value. The result of the comparison is reported through a sticky carry flag.

From the pointer and the current bit-time index, the block produces a word-select window. The window takes one of two shapes: it covers only the pointed digit, or it covers the pointed digit together with every less significant digit. Less significant digits come earlier in time. The generated window is ORed with a word-select line from elsewhere. The same carry flag also records any adder carry that arrives while word-select is high. The flag is cleared once per instruction word.

Top module: `digit_ptr_wsel`

## Requirements
- R1: After reset, `ptr_out` is 0 and `carry_flag` is 0.
- R2: A pulse on `op_set` loads `imm` into the pointer at the next clock edge if `imm` is 13 or less. For an `imm` of 14 or 15 the pointer keeps its value.
- R3: A pulse on `op_inc` adds one to the pointer at the next edge, and 13 wraps to 0.
- R4: A pulse on `op_dec` subtracts one from the pointer at the next edge, and 0 wraps to 13.
- R5: When more than one update strobe is high in a cycle, `op_set` wins over `op_inc`, and `op_inc` wins over `op_dec`. A set with an out-of-range `imm` still blocks the other two.
- R6: A pulse on `op_test` with the pointer different from `imm` sets `carry_flag` at the next edge. When the two are equal, the test alone does not set the flag.
- R7: With `ws_mode` = 1 (single digit), the generated window is high exactly at bit times 4p to 4p+3, where p is the pointer.
- R8: With `ws_mode` = 2 (up to pointer), the generated window is high exactly at bit times 0 to 4p+3.
- R9: With `ws_mode` = 0 or 3, no window is generated.
- R10: `ws_out` is the OR of `ext_ws` and the generated window, combinationally in the same cycle.
- R11: `adder_carry` = 1 while `ws_out` = 1 sets `carry_flag` at the next edge. `adder_carry` with `ws_out` = 0 has no effect.
- R12: `carry_flag` is sticky. It is cleared at the edge that ends a cycle with `bit_time` = 0, unless a set event from R6 or R11 occurs in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_time | input | 6 | Bit-time index within the word, 0 to 55 |
| op_set | input | 1 | Load pointer from `imm` |
| op_inc | input | 1 | Increment pointer |
| op_dec | input | 1 | Decrement pointer |
| op_test | input | 1 | Compare pointer with `imm` |
| imm | input | 4 | Immediate operand |
| ws_mode | input | 2 | 0 none, 1 single digit, 2 up to pointer, 3 none |
| ext_ws | input | 1 | Externally generated word-select |
| adder_carry | input | 1 | Carry out of the serial adder |
| ws_out | output | 1 | Combined word-select |
| ptr_out | output | 4 | Current pointer |
| carry_flag | output | 1 | Sticky carry / test-result flag |

## Verification
The bench aims at both wrap boundaries. A design that computed 13+1 as 14, or 0-1 as 15, would leave the pointer outside the digit range and the window would vanish. It loads out-of-range immediates and raises several strobes in the same cycle, which exposes a loader that accepts 14 or 15 or that gets the priority wrong. At digit edges it samples the window one bit before and one bit after, so an off-by-one in the digit decode or in the up-to comparison is caught. It also drives set events in the same cycle as bit time 0, which separates a flag that lets clear win from one that records the event.

// File: rtl/dpw_pkg.sv
package dpw_pkg;

   typedef enum logic [1:0] {
      WS_NONE     = 2'd0,
      WS_ONE_DIG  = 2'd1,
      WS_UP_TO    = 2'd2,
      WS_SPARE    = 2'd3
   } ws_mode_e;

endpackage

// File: rtl/dpw_ptr_reg.sv
module dpw_ptr_reg #(
   parameter int DIGITS = 14,
   parameter int PTR_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_i,
   input  logic             inc_i,
   input  logic             dec_i,
   input  logic             test_i,
   input  logic [PTR_W-1:0] imm_i,
   output logic [PTR_W-1:0] ptr_o,
   output logic             test_hit_o
);

   localparam logic [PTR_W-1:0] MAX_PTR = PTR_W'(DIGITS - 1);

   logic [PTR_W-1:0] ptr_q;
   logic [PTR_W-1:0] ptr_d;

   always_comb begin
      ptr_d = ptr_q;
      if (set_i) begin
         if (imm_i <= MAX_PTR) ptr_d = imm_i;
      end else if (inc_i) begin
         ptr_d = (ptr_q == MAX_PTR) ? '0 : ptr_q + 1'b1;
      end else if (dec_i) begin
         ptr_d = (ptr_q == '0) ? MAX_PTR : ptr_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q <= '0;
      else        ptr_q <= ptr_d;
   end

   assign ptr_o      = ptr_q;
   assign test_hit_o = test_i && (ptr_q != imm_i);

   assert_ptr_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= MAX_PTR);

   assert_set_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && imm_i <= MAX_PTR) |=> (ptr_q == $past(imm_i)));

   assert_inc_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && inc_i && ptr_q == MAX_PTR) |=> (ptr_q == '0));

   assert_dec_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !inc_i && dec_i && ptr_q == '0) |=> (ptr_q == MAX_PTR));

   assert_bad_set_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && imm_i > MAX_PTR) |=> $stable(ptr_q));

endmodule

// File: rtl/dpw_window.sv
module dpw_window #(
   parameter int DIGITS     = 14,
   parameter int DIG_BITS   = 4,
   parameter int PTR_W      = 4,
   parameter int BT_W       = 6,
   parameter bit MASK_STYLE = 1'b1
) (
   input  logic [BT_W-1:0]  bit_time_i,
   input  logic [PTR_W-1:0] ptr_i,
   input  logic [1:0]       mode_i,
   output logic             win_o
);
   import dpw_pkg::*;

   localparam int CW = (BT_W > PTR_W) ? BT_W : PTR_W;

   ws_mode_e        mode;
   logic [CW-1:0]   digit;
   logic [CW-1:0]   ptr_x;
   logic            in_range;

   assign mode     = ws_mode_e'(mode_i);
   assign digit    = CW'(bit_time_i / BT_W'(DIG_BITS));
   assign ptr_x    = CW'(ptr_i);
   assign in_range = digit < CW'(DIGITS);

   generate
      if (MASK_STYLE) begin : g_mask
         logic [DIGITS-1:0] only_m;
         logic [DIGITS-1:0] upto_m;
         for (genvar k = 0; k < DIGITS; k++) begin : g_dig
            assign only_m[k] = (ptr_x == CW'(k));
            assign upto_m[k] = (ptr_x >= CW'(k));
         end
         logic pick;
         always_comb begin
            pick = 1'b0;
            for (int k = 0; k < DIGITS; k++) begin
               if (digit == CW'(k)) begin
                  case (mode)
                     WS_ONE_DIG: pick = only_m[k];
                     WS_UP_TO:   pick = upto_m[k];
                     default:    pick = 1'b0;
                  endcase
               end
            end
         end
         assign win_o = in_range && pick;
      end else begin : g_cmp
         logic pick;
         always_comb begin
            case (mode)
               WS_ONE_DIG: pick = (digit == ptr_x);
               WS_UP_TO:   pick = (digit <= ptr_x);
               default:    pick = 1'b0;
            endcase
         end
         assign win_o = in_range && pick;
      end
   endgenerate

endmodule

// File: rtl/dpw_carry.sv
module dpw_carry (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic ws_i,
   input  logic adder_carry_i,
   input  logic test_hit_i,
   output logic flag_o
);

   logic flag_q;
   logic set_ev;

   assign set_ev = (ws_i && adder_carry_i) || test_hit_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (set_ev) flag_q <= 1'b1;
      else if (clr_i)  flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   assert_carry_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ws_i && adder_carry_i) |=> flag_q);

   assert_test_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
      test_hit_i |=> flag_q);

   assert_word_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !(ws_i && adder_carry_i) && !test_hit_i) |=> !flag_q);

   assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr_i) |=> flag_q);

endmodule

// File: rtl/digit_ptr_wsel.sv
module digit_ptr_wsel #(
   parameter int DIGITS     = 14,
   parameter int DIG_BITS   = 4,
   parameter int PTR_W      = 4,
   parameter int BT_W       = 6,
   parameter bit MASK_STYLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BT_W-1:0]  bit_time,
   input  logic             op_set,
   input  logic             op_inc,
   input  logic             op_dec,
   input  logic             op_test,
   input  logic [PTR_W-1:0] imm,
   input  logic [1:0]       ws_mode,
   input  logic             ext_ws,
   input  logic             adder_carry,
   output logic             ws_out,
   output logic [PTR_W-1:0] ptr_out,
   output logic             carry_flag
);
   import dpw_pkg::*;

   localparam int WORD_BITS = DIGITS * DIG_BITS;

   generate
      if (DIGITS < 2 || DIGITS > (1 << PTR_W)) begin : g_bad_digits
         $error("DIGITS must fit the pointer width");
      end
      if (WORD_BITS > (1 << BT_W)) begin : g_bad_bt
         $error("bit_time too narrow for the word");
      end
      if (DIG_BITS < 1) begin : g_bad_dig
         $error("DIG_BITS must be positive");
      end
   endgenerate

   logic [PTR_W-1:0] ptr;
   logic             test_hit;
   logic             win;
   logic             ws_int;

   dpw_ptr_reg #(.DIGITS(DIGITS), .PTR_W(PTR_W)) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (op_set),
      .inc_i      (op_inc),
      .dec_i      (op_dec),
      .test_i     (op_test),
      .imm_i      (imm),
      .ptr_o      (ptr),
      .test_hit_o (test_hit)
   );

   dpw_window #(
      .DIGITS(DIGITS), .DIG_BITS(DIG_BITS), .PTR_W(PTR_W),
      .BT_W(BT_W), .MASK_STYLE(MASK_STYLE)
   ) u_win (
      .bit_time_i (bit_time),
      .ptr_i      (ptr),
      .mode_i     (ws_mode),
      .win_o      (win)
   );

   assign ws_int = win || ext_ws;

   dpw_carry u_cy (
      .clk           (clk),
      .rst_n         (rst_n),
      .clr_i         (bit_time == '0),
      .ws_i          (ws_int),
      .adder_carry_i (adder_carry),
      .test_hit_i    (test_hit),
      .flag_o        (carry_flag)
   );

   assign ws_out  = ws_int;
   assign ptr_out = ptr;

   assert_ext_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ext_ws |-> ws_out);

   assert_quiet_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((ws_mode == WS_NONE || ws_mode == WS_SPARE) && !ext_ws) |-> !ws_out);

   assert_single_digit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ws_mode == WS_ONE_DIG && !ext_ws && ws_out) |->
         (BT_W'(bit_time / BT_W'(DIG_BITS)) == BT_W'(ptr_out)));

   assert_upto_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ws_mode == WS_UP_TO && !ext_ws && ws_out) |->
         (BT_W'(bit_time / BT_W'(DIG_BITS)) <= BT_W'(ptr_out)));

endmodule

// File: tb/digit_ptr_wsel_tb.sv
module digit_ptr_wsel_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NRAND      = 3000;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [5:0] bit_time;
   logic       op_set, op_inc, op_dec, op_test;
   logic [3:0] imm;
   logic [1:0] ws_mode;
   logic       ext_ws, adder_carry;
   logic       ws_out;
   logic [3:0] ptr_out;
   logic       carry_flag;

   int checks = 0;
   int fails  = 0;
   int ptr_m  = 0;
   bit flag_m = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   digit_ptr_wsel u_dut (
      .clk(clk), .rst_n(rst_n), .bit_time(bit_time),
      .op_set(op_set), .op_inc(op_inc), .op_dec(op_dec), .op_test(op_test),
      .imm(imm), .ws_mode(ws_mode), .ext_ws(ext_ws), .adder_carry(adder_carry),
      .ws_out(ws_out), .ptr_out(ptr_out), .carry_flag(carry_flag)
   );

   function automatic bit exp_win(int bt, int p, int mode);
      int d = bt / 4;
      if (bt > 55) return 1'b0;
      if (mode == 1) return d == p;
      if (mode == 2) return d <= p;
      return 1'b0;
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic step(string ws_req, string reg_req, int bt, bit s, bit i, bit d,
                       bit t, int im, int mode, bit ext, bit ac);
      bit ws_e;
      int nptr;
      bit nflag;
      @(negedge clk);
      bit_time = 6'(bt); op_set = s; op_inc = i; op_dec = d; op_test = t;
      imm = 4'(im); ws_mode = 2'(mode); ext_ws = ext; adder_carry = ac;
      #1;
      ws_e = ext | exp_win(bt, ptr_m, mode);
      chk(ws_req, int'(ws_out), int'(ws_e));
      nptr = ptr_m;
      if (s) begin
         if (im <= 13) nptr = im;
      end else if (i) nptr = (ptr_m == 13) ? 0 : ptr_m + 1;
      else if (d) nptr = (ptr_m == 0) ? 13 : ptr_m - 1;
      nflag = flag_m;
      if ((ws_e && ac) || (t && ptr_m != im)) nflag = 1'b1;
      else if (bt == 0) nflag = 1'b0;
      @(posedge clk);
      #1;
      ptr_m  = nptr;
      flag_m = nflag;
      chk({reg_req, " ptr"},  int'(ptr_out),    ptr_m);
      chk({reg_req, " flag"}, int'(carry_flag), int'(flag_m));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; bit_time = '0; op_set = 0; op_inc = 0; op_dec = 0; op_test = 0;
      imm = '0; ws_mode = '0; ext_ws = 0; adder_carry = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      chk("R1 ptr",  int'(ptr_out),    0);
      chk("R1 flag", int'(carry_flag), 0);
      chk("R1 ws",   int'(ws_out),     0);

      // pointer loads, wraps and priority
      step("R9",  "R2", 5, 1,0,0,0, 13, 0, 0, 0);
      step("R9",  "R3", 6, 0,1,0,0, 0,  0, 0, 0);
      step("R9",  "R4", 7, 0,0,1,0, 0,  0, 0, 0);
      step("R9",  "R2", 8, 1,0,0,0, 14, 0, 0, 0);
      step("R9",  "R2", 9, 1,0,0,0, 15, 0, 0, 0);
      step("R9",  "R5", 9, 1,1,1,0, 15, 0, 0, 0);
      step("R9",  "R5", 10, 1,1,1,0, 5, 0, 0, 0);
      step("R9",  "R5", 11, 0,1,1,0, 0, 0, 0, 0);

      // pointer is 6: digit 6 spans bit times 24..27
      step("R7", "R7", 23, 0,0,0,0, 0, 1, 0, 0);
      step("R7", "R7", 24, 0,0,0,0, 0, 1, 0, 0);
      step("R7", "R7", 27, 0,0,0,0, 0, 1, 0, 0);
      step("R7", "R7", 28, 0,0,0,0, 0, 1, 0, 0);
      step("R8", "R8", 1,  0,0,0,0, 0, 2, 0, 0);
      step("R8", "R8", 27, 0,0,0,0, 0, 2, 0, 0);
      step("R8", "R8", 28, 0,0,0,0, 0, 2, 0, 0);
      step("R9", "R9", 24, 0,0,0,0, 0, 3, 0, 0);
      step("R9", "R9", 24, 0,0,0,0, 0, 0, 0, 0);
      step("R10", "R10", 40, 0,0,0,0, 0, 0, 1, 0);
      step("R10", "R10", 40, 0,0,0,0, 0, 1, 1, 0);

      // carry flag
      step("R11", "R11", 30, 0,0,0,0, 0, 0, 0, 1);
      step("R11", "R11", 31, 0,0,0,0, 0, 0, 1, 1);
      step("R12", "R12", 32, 0,0,0,0, 0, 0, 0, 0);
      step("R12", "R12", 0,  0,0,0,0, 0, 0, 0, 1);
      step("R12", "R12", 0,  0,0,0,0, 0, 2, 0, 1);
      step("R12", "R12", 0,  0,0,0,0, 0, 0, 0, 0);
      step("R6",  "R6",  3,  0,0,0,1, 6, 0, 0, 0);
      step("R6",  "R6",  4,  0,0,0,1, 2, 0, 0, 0);
      step("R12", "R12", 0,  0,0,0,0, 0, 0, 0, 0);
      step("R6",  "R6",  0,  0,0,0,1, 9, 0, 0, 0);
      step("R3",  "R3",  1,  1,0,0,0, 0, 0, 0, 0);
      step("R4",  "R4",  2,  0,0,1,0, 0, 2, 0, 0);
      step("R8",  "R8",  55, 0,0,0,0, 0, 2, 0, 0);

      // constrained random traffic
      void'($urandom(32'hC0FFEE));
      begin
         int bt = 0;
         int mode = 0;
         for (int n = 0; n < NRAND; n++) begin
            int r = int'($urandom_range(99));
            bit s = (r < 6);
            bit i = (r >= 6 && r < 16) || ($urandom_range(19) == 0);
            bit d = (r >= 16 && r < 26) || ($urandom_range(19) == 0);
            bit t = ($urandom_range(15) == 0);
            int im = int'($urandom_range(15));
            bit ext = ($urandom_range(9) == 0);
            bit ac = ($urandom_range(3) == 0);
            if (bt == 0) mode = int'($urandom_range(3));
            step("R7/R8/R10", "R2/R3/R4/R6/R11/R12", bt, s, i, d, t, im, mode, ext, ac);
            bt = (bt == 55) ? 0 : bt + 1;
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule